// File: doc/BRIEF.md
# Flag Offset Register Unit

This unit keeps the two threshold offsets that a FIFO controller compares against its fill level: one counted up from the empty boundary and one counted down from the full boundary. Its inputs are clocked on the write side. The offsets can be written in either of two ways. In the first, words come in from the write data bus, one part per clock. In the second, a single serial data pin is shifted in one bit per clock. On the read side, the same parts can be read back one word at a time onto the data output bus. The write method in use is fixed when master reset is applied.

While master reset is held, the level of `loadSel` does two things. It sets both offsets to one of two default values. It also selects which write method is active until the next master reset. Outside reset, `loadSel` acts as the qualifier for every offset access. A write, a shift or a readback happens only when `loadSel` and the matching enable are both high at a clock edge. The flag comparison and the FIFO storage are outside this unit. The unit has no partial-reset input: nothing except master reset clears the offsets.

Top module: `flag_offset_unit`

## Requirements
- R1: A master reset taken with `loadSel` low sets `aeOffset` and `afOffset` to 127 and sets `serialMode` to 0, which selects word-wide writes.
- R2: A master reset taken with `loadSel` high sets both offsets to 1023 and sets `serialMode` to 1, which selects bit-serial writes.
- R3: In word mode, each `wrClk` edge with `wrEn` and `loadSel` high writes the next part in a fixed cycle of four parts, then wraps back to the first:
  - part 0: `dataIn[8:0]` to `aeOffset[8:0]`
  - part 1: `dataIn[7:0]` to `aeOffset[16:9]`
  - part 2: `dataIn[8:0]` to `afOffset[8:0]`
  - part 3: `dataIn[7:0]` to `afOffset[16:9]`
- R4: Each `rdClk` edge with `rdEn` and `loadSel` high loads `dataOut` with the next part of its own four-part cycle. The parts are in the same order as R3. The upper parts are zero-extended in bit 8. Readback works in either write mode.
- R5: In serial mode, each `wrClk` edge with `serEn` and `loadSel` high writes `serIn` to the next bit of a 34-bit cycle. The cycle runs through `aeOffset` bits 0 to 16, then `afOffset` bits 0 to 16, then wraps back to `aeOffset` bit 0.
- R6: Master reset returns the write-part cycle, the serial bit cycle and the readback cycle to their first position. It also clears `dataOut` to 0.
- R7: Writes through the method that is not selected are ignored. `serEn` has no effect in word mode, and `wrEn` has no effect in serial mode.
- R8: With `loadSel` low, `wrEn`, `serEn` and `rdEn` leave the offsets and `dataOut` unchanged.
- R9: `serialMode` changes only during master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock; all offset writes and master reset act on its rising edge |
| rdClk | input | 1 | Read-side clock for readback |
| masterRst | input | 1 | Synchronous master reset, active high, sampled by both clocks |
| loadSel | input | 1 | Selects the defaults and the write method during reset; qualifies accesses otherwise |
| wrEn | input | 1 | Word-write enable |
| serEn | input | 1 | Serial-shift enable |
| serIn | input | 1 | Serial data bit |
| dataIn | input | 9 | Word write data |
| rdEn | input | 1 | Readback enable |
| dataOut | output | 9 | Readback word |
| aeOffset | output | 17 | Offset from the empty boundary |
| afOffset | output | 17 | Offset from the full boundary |
| serialMode | output | 1 | 1 when bit-serial writing is selected |

## Verification
The assertions take two things for granted. First, master reset is held across at least one rising edge of each clock. Second, no readback takes place in the same window as an offset write, because the readback side takes the offsets across the clock boundary without synchronising them. The stimulus respects both. It holds master reset for three cycles of each clock, and it finishes every write sequence before it starts reading. Every input is changed on the falling edge, so the enables and `loadSel` are steady at each rising edge.

// File: rtl/offs_pkg.sv
package offs_pkg;

  typedef enum logic [1:0] {
    PART_AE_LO = 2'd0,
    PART_AE_HI = 2'd1,
    PART_AF_LO = 2'd2,
    PART_AF_HI = 2'd3
  } offsPart_e;

  typedef struct packed {
    logic loadDefaults;
    logic defaultHigh;
    logic parLoad;
    logic serLoad;
  } offsStrobe_t;

endpackage

// File: rtl/offs_ctrl.sv
module offs_ctrl
  import offs_pkg::*;
#(
  parameter int OFFSET_W = 17,
  localparam int SER_LEN = 2 * OFFSET_W,
  localparam int SER_W   = $clog2(SER_LEN)
) (
  input  logic              wrClk,
  input  logic              masterRst,
  input  logic              loadSel,
  input  logic              wrEn,
  input  logic              serEn,
  output offsStrobe_t       strobe,
  output offsPart_e         parIdx,
  output logic [SER_W-1:0]  serIdx,
  output logic              serialMode
);

  localparam logic [SER_W-1:0] SER_LAST = SER_W'(SER_LEN - 1);

  always_comb begin
    strobe.loadDefaults = masterRst;
    strobe.defaultHigh  = loadSel;
    strobe.parLoad      = !masterRst && !serialMode && loadSel && wrEn;
    strobe.serLoad      = !masterRst &&  serialMode && loadSel && serEn;
  end

  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      serialMode <= loadSel;
      parIdx     <= PART_AE_LO;
      serIdx     <= '0;
    end else begin
      if (strobe.parLoad) parIdx <= offsPart_e'(parIdx + 2'd1);
      if (strobe.serLoad) serIdx <= (serIdx == SER_LAST) ? '0 : serIdx + 1'b1;
    end
  end

  // R9
  mode_hold_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    !$past(masterRst) |-> $stable(serialMode));

  // R5
  ser_wrap_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    (strobe.serLoad && serIdx == SER_LAST) |=> serIdx == '0);

  // R3
  par_step_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    strobe.parLoad |=> parIdx == offsPart_e'($past(parIdx) + 2'd1));

endmodule

// File: rtl/offs_dpath.sv
module offs_dpath
  import offs_pkg::*;
#(
  parameter int OFFSET_W = 17,
  parameter int DATA_W   = 9,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023,
  localparam int SER_W   = $clog2(2 * OFFSET_W),
  localparam int HI_W    = OFFSET_W - DATA_W
) (
  input  logic              wrClk,
  input  logic              masterRst,
  input  offsStrobe_t       strobe,
  input  offsPart_e         parIdx,
  input  logic [SER_W-1:0]  serIdx,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [OFFSET_W-1:0] aeOffset,
  output logic [OFFSET_W-1:0] afOffset
);

  logic [2*OFFSET_W-1:0] offsReg;
  logic [OFFSET_W-1:0]   defVal;

  assign defVal   = strobe.defaultHigh ? OFFSET_W'(DEF_HIGH) : OFFSET_W'(DEF_LOW);
  assign aeOffset = offsReg[OFFSET_W-1:0];
  assign afOffset = offsReg[2*OFFSET_W-1:OFFSET_W];

  always_ff @(posedge wrClk) begin
    if (strobe.loadDefaults) begin
      offsReg <= {defVal, defVal};
    end else if (strobe.parLoad) begin
      case (parIdx)
        PART_AE_LO: offsReg[DATA_W-1:0]                   <= dataIn;
        PART_AE_HI: offsReg[OFFSET_W-1:DATA_W]            <= dataIn[HI_W-1:0];
        PART_AF_LO: offsReg[OFFSET_W+DATA_W-1:OFFSET_W]   <= dataIn;
        PART_AF_HI: offsReg[2*OFFSET_W-1:OFFSET_W+DATA_W] <= dataIn[HI_W-1:0];
        default:    ;
      endcase
    end else if (strobe.serLoad) begin
      offsReg[serIdx] <= serIn;
    end
  end

  // R8
  offs_hold_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    !(strobe.parLoad || strobe.serLoad) |=> ($stable(aeOffset) && $stable(afOffset)));

  // R3
  par_ae_lo_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    (strobe.parLoad && parIdx == PART_AE_LO) |=> aeOffset[DATA_W-1:0] == $past(dataIn));

  // R5
  ser_first_chk: assert property (@(posedge wrClk) disable iff (masterRst)
    (strobe.serLoad && serIdx == '0) |=> aeOffset[0] == $past(serIn));

endmodule

// File: rtl/offs_readback.sv
module offs_readback
  import offs_pkg::*;
#(
  parameter int OFFSET_W = 17,
  parameter int DATA_W   = 9,
  localparam int HI_W    = OFFSET_W - DATA_W
) (
  input  logic                rdClk,
  input  logic                masterRst,
  input  logic                loadSel,
  input  logic                rdEn,
  input  logic [OFFSET_W-1:0] aeOffset,
  input  logic [OFFSET_W-1:0] afOffset,
  output logic [DATA_W-1:0]   dataOut
);

  offsPart_e         rdPtr;
  logic              rdStep;
  logic [DATA_W-1:0] partWord;

  assign rdStep = !masterRst && rdEn && loadSel;

  always_comb begin
    case (rdPtr)
      PART_AE_LO: partWord = aeOffset[DATA_W-1:0];
      PART_AE_HI: partWord = {{(DATA_W-HI_W){1'b0}}, aeOffset[OFFSET_W-1:DATA_W]};
      PART_AF_LO: partWord = afOffset[DATA_W-1:0];
      default:    partWord = {{(DATA_W-HI_W){1'b0}}, afOffset[OFFSET_W-1:DATA_W]};
    endcase
  end

  always_ff @(posedge rdClk) begin
    if (masterRst) begin
      rdPtr   <= PART_AE_LO;
      dataOut <= '0;
    end else if (rdStep) begin
      rdPtr   <= offsPart_e'(rdPtr + 2'd1);
      dataOut <= partWord;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge rdClk) disable iff (masterRst)
    !rdStep |=> $stable(dataOut));

  // R4
  rd_step_chk: assert property (@(posedge rdClk) disable iff (masterRst)
    rdStep |=> rdPtr == offsPart_e'($past(rdPtr) + 2'd1));

  // R6
  rd_restart_chk: assert property (@(posedge rdClk)
    $past(masterRst) |-> (rdPtr == PART_AE_LO || !masterRst && $past(rdStep)));

endmodule

// File: rtl/flag_offset_unit.sv
module flag_offset_unit
  import offs_pkg::*;
#(
  parameter int OFFSET_W = 17,
  parameter int DATA_W   = 9,
  parameter int DEF_LOW  = 127,
  parameter int DEF_HIGH = 1023,
  localparam int SER_W   = $clog2(2 * OFFSET_W)
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                masterRst,
  input  logic                loadSel,
  input  logic                wrEn,
  input  logic                serEn,
  input  logic                serIn,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                rdEn,
  output logic [DATA_W-1:0]   dataOut,
  output logic [OFFSET_W-1:0] aeOffset,
  output logic [OFFSET_W-1:0] afOffset,
  output logic                serialMode
);

  offsStrobe_t      strobe;
  offsPart_e        parIdx;
  logic [SER_W-1:0] serIdx;

  offs_ctrl #(.OFFSET_W(OFFSET_W)) u_ctrl (
    .wrClk(wrClk), .masterRst(masterRst), .loadSel(loadSel), .wrEn(wrEn),
    .serEn(serEn), .strobe(strobe), .parIdx(parIdx), .serIdx(serIdx),
    .serialMode(serialMode)
  );

  offs_dpath #(.OFFSET_W(OFFSET_W), .DATA_W(DATA_W), .DEF_LOW(DEF_LOW),
               .DEF_HIGH(DEF_HIGH)) u_dpath (
    .wrClk(wrClk), .masterRst(masterRst), .strobe(strobe), .parIdx(parIdx),
    .serIdx(serIdx), .serIn(serIn), .dataIn(dataIn),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );

  offs_readback #(.OFFSET_W(OFFSET_W), .DATA_W(DATA_W)) u_readback (
    .rdClk(rdClk), .masterRst(masterRst), .loadSel(loadSel), .rdEn(rdEn),
    .aeOffset(aeOffset), .afOffset(afOffset), .dataOut(dataOut)
  );

endmodule

// File: tb/flag_offset_unit_bench.sv
`timescale 1ns/1ps
module flag_offset_unit_bench;

  logic        wrClk = 0, rdClk = 0;
  logic        masterRst = 1, loadSel = 0, wrEn = 0, serEn = 0, serIn = 0, rdEn = 0;
  logic [8:0]  dataIn = '0;
  logic [8:0]  dataOut;
  logic [16:0] aeOffset, afOffset;
  logic        serialMode;

  int nChecks = 0, nFails = 0;
  logic [16:0] mAe, mAf;
  bit          mSerial;
  int          mParIdx, mSerIdx, mRdIdx;
  logic [8:0]  expQ[$];
  string       reqQ[$];

  always #2 wrClk = ~wrClk;
  always #2 rdClk = ~rdClk;

  flag_offset_unit u_flag_offset_unit (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .loadSel(loadSel),
    .wrEn(wrEn), .serEn(serEn), .serIn(serIn), .dataIn(dataIn), .rdEn(rdEn),
    .dataOut(dataOut), .aeOffset(aeOffset), .afOffset(afOffset),
    .serialMode(serialMode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] partOf(int idx);
    case (idx)
      0: return mAe[8:0];
      1: return {1'b0, mAe[16:9]};
      2: return mAf[8:0];
      default: return {1'b0, mAf[16:9]};
    endcase
  endfunction

  task automatic doReset(bit lsel);
    @(negedge wrClk);
    masterRst = 1; loadSel = lsel;
    repeat (3) @(negedge wrClk);
    masterRst = 0; loadSel = 0;
    mAe = lsel ? 17'd1023 : 17'd127; mAf = mAe; mSerial = lsel;
    mParIdx = 0; mSerIdx = 0; mRdIdx = 0;
  endtask

  task automatic parWrite(logic [8:0] w, bit lsel);
    @(negedge wrClk);
    wrEn = 1; loadSel = lsel; dataIn = w;
    @(negedge wrClk);
    wrEn = 0; loadSel = 0;
    if (lsel && !mSerial) begin
      case (mParIdx)
        0: mAe[8:0]  = w;
        1: mAe[16:9] = w[7:0];
        2: mAf[8:0]  = w;
        default: mAf[16:9] = w[7:0];
      endcase
      mParIdx = (mParIdx + 1) % 4;
    end
  endtask

  task automatic serWrite(bit b, bit lsel);
    @(negedge wrClk);
    serEn = 1; loadSel = lsel; serIn = b;
    @(negedge wrClk);
    serEn = 0; loadSel = 0;
    if (lsel && mSerial) begin
      if (mSerIdx < 17) mAe[mSerIdx] = b; else mAf[mSerIdx-17] = b;
      mSerIdx = (mSerIdx + 1) % 34;
    end
  endtask

  task automatic readPart(string req);
    expQ.push_back(partOf(mRdIdx)); reqQ.push_back(req);
    mRdIdx = (mRdIdx + 1) % 4;
    @(negedge rdClk);
    rdEn = 1; loadSel = 1;
    @(negedge rdClk);
    rdEn = 0; loadSel = 0;
  endtask

  // monitor: compares each readback word against the scoreboard queue
  always @(posedge rdClk) begin
    if (!masterRst && rdEn && loadSel) begin
      #1;
      if (expQ.size() == 0) check("R4 unexpected read", 32'(dataOut), 32'hFFFF_FFFF);
      else check(reqQ.pop_front(), 32'(dataOut), 32'(expQ.pop_front()));
    end
  end

  task automatic checkOffsets(string req);
    check(req, 32'(aeOffset), 32'(mAe));
    check(req, 32'(afOffset), 32'(mAf));
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [16:0] sA, sB;
    logic [8:0]  heldOut;
    // R1 defaults, word mode
    doReset(0);
    checkOffsets("R1 defaults");
    check("R1 mode", 32'(serialMode), 0);
    check("R6 dataOut cleared", 32'(dataOut), 0);
    for (int i = 0; i < 5; i++) readPart("R4 default readback");
    // R3 word writes
    parWrite(9'h1A5, 1); parWrite(9'h03C, 1); parWrite(9'h0FF, 1); parWrite(9'h181, 1);
    checkOffsets("R3 word write");
    check("R3 ae value", 32'(aeOffset), 32'({8'h3C, 9'h1A5}));
    mRdIdx = 0;
    doReset(0); // restart sequences (R6), then load again
    parWrite(9'h1A5, 1); parWrite(9'h03C, 1); parWrite(9'h0FF, 1); parWrite(9'h181, 1);
    parWrite(9'h022, 1); // wraps to ae low part
    checkOffsets("R3 wrap");
    for (int i = 0; i < 4; i++) readPart("R4 word readback");
    // R7 serial ignored in word mode
    for (int i = 0; i < 5; i++) serWrite(1, 1);
    checkOffsets("R7 serial ignored");
    // R8 no loadSel
    parWrite(9'h155, 0); serWrite(1, 0);
    checkOffsets("R8 writes without loadSel");
    heldOut = dataOut;
    @(negedge rdClk); rdEn = 1; @(negedge rdClk); rdEn = 0;
    check("R8 read without loadSel", 32'(dataOut), 32'(heldOut));
    // R6 mid-sequence reset
    parWrite(9'h011, 1);
    readPart("R4 partial"); 
    doReset(0);
    parWrite(9'h0AA, 1);
    check("R6 write sequence restart", 32'(aeOffset[8:0]), 32'h0AA);
    readPart("R6 read sequence restart");
    // R2 serial mode
    doReset(1);
    checkOffsets("R2 defaults");
    check("R2 mode", 32'(serialMode), 1);
    for (int i = 0; i < 4; i++) readPart("R4 serial-mode default readback");
    parWrite(9'h0F0, 1);
    checkOffsets("R7 word write ignored");
    check("R9 mode held", 32'(serialMode), 1);
    // R5 serial shift
    sA = 17'h12345; sB = 17'h0ABCD;
    for (int i = 0; i < 34; i++) serWrite(i < 17 ? sA[i] : sB[i-17], 1);
    check("R5 ae serial", 32'(aeOffset), 32'(sA));
    check("R5 af serial", 32'(afOffset), 32'(sB));
    serWrite(0, 1); serWrite(1, 1); serWrite(0, 1);
    check("R5 serial wrap", 32'(aeOffset), 32'h12342);
    checkOffsets("R5 model");
    mRdIdx = 0;
    doReset(1);
    for (int i = 0; i < 34; i++) serWrite(i < 17 ? sA[i] : sB[i-17], 1);
    for (int i = 0; i < 4; i++) readPart("R4 serial-mode readback");
    repeat (4) @(negedge rdClk);
    check("R4 queue drained", 32'(expQ.size()), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule